// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Rate Prescaler

This block moves one byte at a time over a four-wire serial link and can act as either the clock-driving side (master) or the clocked side (slave). Software programs a control register, writes a byte to the data register and later reads back the byte that came in. In master mode the write itself launches the transfer. A 3-bit rate code sets the serial clock as a power-of-two fraction of the system clock. Two control bits set the serial clock's resting level and which of its edges samples and which shifts. In slave mode the incoming clock, data and select lines pass through two-flop synchronisers before any edge is acted on.

A sticky completion flag and a write-collision flag sit in the status register. Both clear when software reads the status register while a flag is set and then accesses the data register.

Top module: `spi_rate_ctrl`

## Requirements
- R1: Out of reset every register reads 0, `sck_o` is 1, and `mosi_oe` and `miso_oe` are 0. The register map is address 0 = control, 1 = status, 2 = data. The control byte holds rate in [7:5], enable in [4], select-ignore in [3], master in [2], CPOL in [1] and CPHA in [0]. The status byte holds the completion flag in bit 7 and the collision flag in bit 6.
- R2: In master mode one SCK half-period lasts `div` system clocks. Rate codes 0 to 6 give `div` = 2, 4, 8, 16, 32, 64, 128, and code 7 gives `div` = 1. The first SCK transition comes `div` clocks after the clock edge that accepts the data write.
- R3: A master transfer makes exactly 16 SCK transitions and leaves SCK at the CPOL level. It shifts the written byte out on MOSI MSB first and assembles the byte seen on MISO, which the data address then returns.
- R4: With CPHA = 0, input is sampled on the first (leading) edge of each bit and output changes on the trailing edge. With CPHA = 1, output changes on the leading edge and input is sampled on the trailing edge.
- R5: While enable is 0, `sck_o` is 1 whatever CPOL holds.
- R6: The completion flag rises on the same clock edge as the 16th SCK transition, so it is visible 16·`div` clocks after the write edge and not one clock earlier.
- R7: The flags stay set until a status read made while a flag is set is followed by a data-register access. A status read alone leaves them set.
- R8: A data write during a transfer is discarded and the transmitted byte is unchanged. It sets the collision flag.
- R9: In slave mode the block samples MOSI and drives MISO on edges of the external SCK, using the same CPOL/CPHA rules. The external SCK must run at no more than one quarter of the system clock. After 8 bits the completion flag sets and the data register holds the received byte.
- R10: In slave mode `miso_oe` is 0 while SS is high. SS rising part-way through a byte discards the partial count, and the next full byte is received correctly.
- R11: With select-ignore set, a slave transfers with `miso_oe` driven even though SS is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the flag-clear sequence) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| sck_i | input | 1 | Serial clock in (slave mode) |
| sck_o | output | 1 | Serial clock out |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line, input (slave mode) |
| mosi_o | output | 1 | Master-out line, output |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line, input (master mode) |
| miso_o | output | 1 | Master-in line, output |
| miso_oe | output | 1 | Master-in output enable |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
For a data write accepted at clock edge T0, SCK transition k is due at edge T0 + k·`div`, and the completion flag is due at T0 + 16·`div`. The bench logs the write's cycle number, and its monitor compares every observed SCK transition against that schedule. The driver probes the status flag one clock before its due edge and on that edge. Slave-mode results lag the pins by the synchroniser depth, so the bench holds each SCK half-period for eight clocks and samples MISO only at the end of a half-period.

// File: rtl/spi_rc_pkg.sv
package spi_rc_pkg;
    localparam int DW    = 8;                  // bits per transfer
    localparam int RW    = 3;                  // rate code width
    localparam int ECW   = $clog2(2 * DW);     // SCK edge counter width
    localparam int EDGES = 2 * DW;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    typedef struct packed {
        logic [RW-1:0] rate;
        logic          en;
        logic          ss_ign;
        logic          mst;
        logic          cpol;
        logic          cpha;
    } ctrl_t;

    typedef struct packed {
        ctrl_t          ctrl;
        logic [DW-1:0]  sh;
        logic [DW-1:0]  rxb;
        logic           out_bit;
        logic           sck;
        logic           sck_prev;
        logic [ECW-1:0] ecnt;
        logic           busy;
        logic           done;
        logic           wcol;
        logic           armed;
    } core_t;
endpackage

// File: rtl/spi_rc_prescale.sv
module spi_rc_prescale #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = (1 << RATE_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   full;
    logic [CNT_W-1:0] lim;

    assign full = {{CNT_W{1'b0}}, 1'b1} << (rate + 1'b1);
    assign lim  = (rate == '1) ? '0 : CNT_W'(full - 1'b1);
    assign tick = (cnt_q == lim);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (clr || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rate != '1) |=> (!tick || rate == '1));
endmodule

// File: rtl/spi_rc_sync.sv
module spi_rc_sync #(
    parameter int         W   = 3,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST;
            s2_q <= RST;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/spi_rate_ctrl.sv
module spi_rate_ctrl
    import spi_rc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       mosi_i,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe,
    input  logic       ss_n_i
);
    core_t q, n;

    logic       tick, pre_clr;
    logic [2:0] pins_s;
    logic       sck_s, mosi_s, ss_s;
    logic       wr_ctrl, wr_data, rd_stat, rd_data, data_acc;
    logic       is_mst, is_slv, sel, in_xfer;
    logic       rise, fall, mst_ev, slv_ev, ev, lead, samp, in_bit;
    logic [DW-1:0] shifted;

    spi_rc_prescale #(.RATE_W(RW)) i_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .rate(q.ctrl.rate), .tick(tick)
    );

    spi_rc_sync #(.W(3), .RST(3'b100)) i_sync (
        .clk(clk), .rst_n(rst_n), .din({ss_n_i, mosi_i, sck_i}), .dout(pins_s)
    );
    assign sck_s  = pins_s[0];
    assign mosi_s = pins_s[1];
    assign ss_s   = pins_s[2];

    assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
    assign wr_data  = reg_wr && reg_addr == A_DATA;
    assign rd_stat  = reg_rd && reg_addr == A_STAT;
    assign rd_data  = reg_rd && reg_addr == A_DATA;
    assign data_acc = wr_data || rd_data;

    assign is_mst  = q.ctrl.en && q.ctrl.mst;
    assign is_slv  = q.ctrl.en && !q.ctrl.mst;
    assign sel     = q.ctrl.ss_ign || !ss_s;
    assign in_xfer = q.busy || (is_slv && q.ecnt != '0);

    assign rise    = sck_s && !q.sck_prev;
    assign fall    = !sck_s && q.sck_prev;
    assign mst_ev  = q.busy && tick;
    assign slv_ev  = is_slv && sel && (rise || fall);
    assign ev      = mst_ev || slv_ev;
    assign lead    = q.busy ? !q.ecnt[0] : (rise ^ q.ctrl.cpol);
    assign samp    = lead ^ q.ctrl.cpha;
    assign in_bit  = q.busy ? miso_i : mosi_s;
    assign shifted = {q.sh[DW-2:0], in_bit};

    always_comb begin
        n          = q;
        pre_clr    = 1'b0;
        n.sck_prev = sck_s;
        if (wr_ctrl) n.ctrl = ctrl_t'(reg_wdata);
        // flag clear sequence, then flag set (set wins)
        if (data_acc && q.armed) begin
            n.done  = 1'b0;
            n.wcol  = 1'b0;
            n.armed = 1'b0;
        end
        if (rd_stat && (q.done || q.wcol)) n.armed = 1'b1;
        if (wr_data) begin
            if (in_xfer) begin
                n.wcol = 1'b1;
            end else begin
                n.sh      = reg_wdata;
                n.out_bit = reg_wdata[DW-1];
                n.ecnt    = '0;
                if (is_mst) begin
                    n.busy  = 1'b1;
                    pre_clr = 1'b1;
                end
            end
        end
        if (ev) begin
            if (samp) n.sh      = shifted;
            else      n.out_bit = q.sh[DW-1];
            n.ecnt = q.ecnt + 1'b1;
            if (q.busy) n.sck = !q.sck;
            if (q.ecnt == ECW'(EDGES - 1)) begin
                n.done = 1'b1;
                n.busy = 1'b0;
                n.ecnt = '0;
                n.rxb  = samp ? shifted : q.sh;
            end
        end
        if (is_slv && !sel)       n.ecnt = '0;
        if (q.busy && !is_mst) begin
            n.busy = 1'b0;
            n.ecnt = '0;
        end
        if (!q.ctrl.en) begin
            n.busy = 1'b0;
            n.ecnt = '0;
        end
        if (!n.busy) n.sck = n.ctrl.en ? n.ctrl.cpol : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.sck <= 1'b1;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = q.ctrl;
            A_STAT:  reg_rdata = {q.done, q.wcol, {(DW-2){1'b0}}};
            A_DATA:  reg_rdata = q.rxb;
            default: reg_rdata = '0;
        endcase
    end

    assign sck_o   = q.sck;
    assign sck_oe  = !q.ctrl.en || q.ctrl.mst;
    assign mosi_o  = q.out_bit;
    assign mosi_oe = is_mst;
    assign miso_o  = q.out_bit;
    assign miso_oe = is_slv && sel;

    // R5
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ctrl.en && !wr_ctrl) |=> sck_o);
    // R2
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !tick && !wr_ctrl) |=> $stable(sck_o));
    // R8
    wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && wr_data) |=> (reg_addr != A_STAT || reg_rdata[6]) && q.wcol);
    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !(data_acc && q.armed)) |=> q.done);
    // R10
    miso_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_s && !q.ctrl.ss_ign) |-> !miso_oe);
endmodule

// File: tb/test_spi_rate_ctrl.sv
module test_spi_rate_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int H = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0, reg_rdata;
    logic sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
    logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

    int nchk = 0, nfail = 0, cyc = 0;

    typedef struct {
        logic [7:0] tx;
        int         div;
        logic       cpol;
        int         wcyc;
    } exp_t;
    exp_t sb_q[$];

    logic       mon_on = 1'b0, prev_sck = 1'b1, mcpol = 1'b0, mcpha = 1'b0, mlead;
    logic [7:0] cap = 8'd0, sbyte = 8'd0;
    int         tog = 0, sidx = 0, tbad = 0;

    spi_rate_ctrl i_spi_rate_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o),
        .miso_oe(miso_oe), .ss_n_i(ss_n_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input int act, input int exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int divf(input logic [2:0] r);
        return (r == 3'd7) ? 1 : (2 << r);
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // monitor: bench-side slave model plus scoreboard compare
    always @(negedge clk) begin
        if (mon_on && sck_o !== prev_sck) begin
            tog++;
            mlead = (sck_o != mcpol);
            if (mlead ^ mcpha) cap = {cap[6:0], mosi_o};
            else if (sidx >= 0) begin miso_i = sbyte[sidx]; sidx--; end
            if (sb_q.size() > 0 && cyc != sb_q[0].wcyc + tog * sb_q[0].div) tbad++;
            if (tog == 16 && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(cap, e.tx, "R3 R4 MOSI byte MSB first");
                #1 check(sck_o, e.cpol, "R3 SCK rests at CPOL");
                check(tbad, 0, "R2 SCK transition schedule");
            end
        end
        prev_sck = sck_o;
    end

    task automatic master_xfer(input logic cpol, input logic cpha, input logic [2:0] rate,
                               input logic [7:0] tx, input logic [7:0] sl, input bit coll);
        logic [7:0] d;
        exp_t e;
        int dv;
        dv = divf(rate);
        reg_write(2'd0, {rate, 1'b1, 1'b0, 1'b1, cpol, cpha});
        mcpol = cpol; mcpha = cpha; sbyte = sl; cap = 8'd0; tog = 0; tbad = 0;
        if (!cpha) begin miso_i = sl[7]; sidx = 6; end
        else sidx = 7;
        @(negedge clk);
        mon_on = 1'b1;
        reg_write(2'd2, tx);
        e.tx = tx; e.div = dv; e.cpol = cpol; e.wcyc = cyc;
        sb_q.push_back(e);
        if (!coll) begin
            repeat (16 * dv - 1) @(negedge clk);
            peek(2'd1, d);
            check(d[7], 0, "R6 flag not yet set one clock early");
            @(negedge clk);
            peek(2'd1, d);
            check(d[7], 1, "R6 flag set on 16th transition");
        end else begin
            repeat (3) @(negedge clk);
            reg_write(2'd2, ~tx);
            for (int i = 0; i < 40 * dv; i++) @(negedge clk);
        end
        reg_read(2'd1, d);
        check(d, coll ? 8'hC0 : 8'h80, coll ? "R8 collision status" : "R6 status byte");
        peek(2'd1, d);
        check(d[7], 1, "R7 status read alone keeps flag");
        reg_read(2'd2, d);
        check(d, sl, "R3 received byte");
        peek(2'd1, d);
        check(d, 0, "R7 flags cleared after status then data");
        mon_on = 1'b0;
    endtask

    task automatic send_bits(input int nb, input logic [7:0] mb, input logic cpol,
                             input logic cpha, inout logic [7:0] c);
        for (int i = 0; i < nb; i++) begin
            if (!cpha) begin
                mosi_i = mb[7-i];
                repeat (H) @(negedge clk);
                c = {c[6:0], miso_o};
                sck_i = ~cpol;
                repeat (H) @(negedge clk);
                sck_i = cpol;
            end else begin
                sck_i = ~cpol;
                mosi_i = mb[7-i];
                repeat (H) @(negedge clk);
                c = {c[6:0], miso_o};
                sck_i = cpol;
                repeat (H) @(negedge clk);
            end
        end
    endtask

    task automatic slave_xfer(input logic cpol, input logic cpha, input logic [7:0] mb,
                              input logic [7:0] st, input bit abort, input bit ign);
        logic [7:0] d, c;
        c = 8'd0;
        ss_n_i = 1'b1;
        sck_i = cpol;
        repeat (4) @(negedge clk);
        reg_write(2'd0, {3'd0, 1'b1, ign, 1'b0, cpol, cpha});
        reg_write(2'd2, st);
        repeat (4) @(negedge clk);
        check(miso_oe, ign, ign ? "R11 MISO driven with SS ignored" : "R10 MISO off while SS high");
        if (!ign) ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        check(miso_oe, 1, "R9 MISO driven when selected");
        if (abort) begin
            send_bits(3, 8'hE0, cpol, cpha, c);
            repeat (H) @(negedge clk);
            ss_n_i = 1'b1;
            repeat (H) @(negedge clk);
            peek(2'd1, d);
            check(d[7], 0, "R10 abort leaves flag clear");
            ss_n_i = 1'b0;
            repeat (H) @(negedge clk);
        end
        send_bits(8, mb, cpol, cpha, c);
        repeat (H) @(negedge clk);
        if (!abort) check(c, st, "R9 byte on MISO");
        reg_read(2'd1, d);
        check(d[7], 1, "R9 slave completion flag");
        reg_read(2'd2, d);
        check(d, mb, abort ? "R10 byte after abort" : "R9 slave received byte");
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sck_o, 1, "R1 reset SCK high");
        check(mosi_oe, 0, "R1 reset MOSI enable");
        check(miso_oe, 0, "R1 reset MISO enable");
        peek(2'd0, d); check(d, 0, "R1 reset control");
        peek(2'd1, d); check(d, 0, "R1 reset status");

        reg_write(2'd0, 8'b000_0_0_1_1_0);
        @(negedge clk);
        check(sck_o, 1, "R5 disabled CPOL=1");
        reg_write(2'd0, 8'b000_0_0_1_0_0);
        @(negedge clk);
        check(sck_o, 1, "R5 disabled CPOL=0");
        reg_write(2'd0, 8'b000_1_0_1_0_0);
        @(negedge clk);
        check(sck_o, 0, "R3 enabled idle at CPOL");

        master_xfer(1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C, 1'b0);
        master_xfer(1'b0, 1'b1, 3'd1, 8'h81, 8'h7E, 1'b0);
        master_xfer(1'b1, 1'b0, 3'd7, 8'h5A, 8'hC3, 1'b0);
        master_xfer(1'b1, 1'b1, 3'd2, 8'h01, 8'hF0, 1'b0);
        master_xfer(1'b0, 1'b0, 3'd6, 8'hE7, 8'h19, 1'b0);
        master_xfer(1'b1, 1'b1, 3'd3, 8'h96, 8'h6B, 1'b1);

        slave_xfer(1'b0, 1'b0, 8'hB4, 8'h2D, 1'b0, 1'b0);
        slave_xfer(1'b1, 1'b1, 8'h4B, 8'hD2, 1'b0, 1'b0);
        slave_xfer(1'b0, 1'b1, 8'hC6, 8'h00, 1'b1, 1'b0);
        slave_xfer(1'b1, 1'b0, 8'h39, 8'hA7, 1'b0, 1'b1);

        check(sb_q.size(), 0, "R3 scoreboard drained");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule